// File: doc/BRIEF.md
# Chained DMA Block Descriptor Loader

This block sits beside the data-moving engine of one DMA channel and feeds it block descriptors when the channel works through a chained array of blocks. Each descriptor in memory is three consecutive 16-bit words: the upper half of a 32-bit memory address, then the lower half at byte offset +2, then the block transfer count at byte offset +4. The loader reads these words through a simple request/valid read port. It assembles them and hands address and count to the engine in a single load pulse.

A start command captures a descriptor-array pointer and a count of remaining blocks. If that count is nonzero, the loader decrements it and fetches the first descriptor. If the count is zero, the loader fetches nothing and lets the engine run on whatever it already holds. Each time the engine reports that a block has finished, the loader checks the remaining count. If it is nonzero, the loader decrements it, moves the pointer forward by six bytes and fetches the next descriptor, and the channel stays active. If it is zero, the loader raises a one-cycle chain-finished pulse and goes idle. An abort cancels any fetch in flight.

Top module: `dma_chain_loader`

## Requirements
- R1: After reset the loader is idle: `active_o`, `rd_req_o`, `ld_valid_o` and `chain_done_o` are all low.
- R2: A start while idle raises `active_o` on the next cycle. With a nonzero `blk_cnt_i`, descriptor reads begin in that same cycle. With `blk_cnt_i` zero, no read is issued, and the first `block_done_i` ends the chain.
- R3: A descriptor is read as three words, in order, at byte addresses pointer+0, pointer+2 and pointer+4. `rd_req_o` and `rd_addr_o` hold steady until `rd_valid_i` accepts each word.
- R4: One cycle after the third word is accepted, `ld_valid_o` pulses for exactly one cycle. `ld_addr_o` then equals (first word << 16) | second word, and `ld_count_o` equals the third word. No read is requested in that cycle.
- R5: A `block_done_i` while blocks remain restarts the fetch at the pointer plus 6. `active_o` stays high and `chain_done_o` stays low. A start with count N therefore produces exactly N load pulses.
- R6: A `block_done_i` when no blocks remain pulses `chain_done_o` for one cycle, with `active_o` low in that same cycle.
- R7: An abort during a descriptor fetch returns the loader to idle on the next cycle. No load pulse and no chain-finished pulse are produced.
- R8: A start while active is ignored, and so is a `block_done_i` during a fetch. Neither changes the read addresses, loads or completion that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a chained transfer |
| base_addr_i | input | 32 | Byte pointer to the first descriptor, captured at start |
| blk_cnt_i | input | 16 | Number of descriptors to load, captured at start |
| block_done_i | input | 1 | Engine reports the current block finished |
| abort_i | input | 1 | Cancel the chain |
| rd_req_o | output | 1 | Descriptor word read request |
| rd_addr_o | output | 32 | Byte address of the requested word |
| rd_valid_i | input | 1 | Read data valid; accepts the current request |
| rd_data_i | input | 16 | Read data word |
| ld_valid_o | output | 1 | One-cycle load strobe to the engine |
| ld_addr_o | output | 32 | Memory address to load |
| ld_count_o | output | 16 | Transfer count to load |
| active_o | output | 1 | Channel busy with a chain |
| chain_done_o | output | 1 | One-cycle final completion pulse |

## Verification
The hardest case to reach from the ports is an abort that lands in the middle of a descriptor, after some words have been accepted but before the load. The same goes for a block-done or a second start that arrives while words are still pending. The bench's memory responder stretches each read by zero to two cycles, depending on the address. The bench then times aborts and spurious commands against the accepted-word count tracked by its own reference model. Every output is compared with that model on every clock.

// File: rtl/dma_chain_loader_pkg.sv
package dma_chain_loader_pkg;

    typedef enum logic [1:0] {
        LDR_IDLE  = 2'd0,
        LDR_FETCH = 2'd1,
        LDR_RUN   = 2'd2
    } ldr_state_e;

endpackage

// File: rtl/dcl_word_gather.sv
module dcl_word_gather #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              take_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [1:0]        idx_o,
    output logic              last_o,
    output logic [WORD_W-1:0] hi_o,
    output logic [WORD_W-1:0] lo_o
);

    localparam logic [1:0] LAST_IDX = 2'd2;

    typedef struct packed {
        logic [1:0]        idx;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } gather_t;

    gather_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (clr_i) begin
            g_d.idx = '0;
        end else if (take_i) begin
            case (g_q.idx)
                2'd0:    g_d.hi = data_i;
                2'd1:    g_d.lo = data_i;
                default: ;
            endcase
            g_d.idx = (g_q.idx == LAST_IDX) ? 2'd0 : g_q.idx + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign idx_o  = g_q.idx;
    assign last_o = (g_q.idx == LAST_IDX);
    assign hi_o   = g_q.hi;
    assign lo_o   = g_q.lo;

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.idx != 2'd3);  // R3

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !clr_i && g_q.idx != LAST_IDX) |=> (g_q.idx == $past(g_q.idx) + 2'd1));  // R3

endmodule

// File: rtl/dma_chain_loader.sv
module dma_chain_loader
    import dma_chain_loader_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [2*WORD_W-1:0] base_addr_i,
    input  logic [CNT_W-1:0]    blk_cnt_i,
    input  logic                block_done_i,
    input  logic                abort_i,
    output logic                rd_req_o,
    output logic [2*WORD_W-1:0] rd_addr_o,
    input  logic                rd_valid_i,
    input  logic [WORD_W-1:0]   rd_data_i,
    output logic                ld_valid_o,
    output logic [2*WORD_W-1:0] ld_addr_o,
    output logic [WORD_W-1:0]   ld_count_o,
    output logic                active_o,
    output logic                chain_done_o
);

    localparam int AW         = 2 * WORD_W;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int DESC_BYTES = 3 * WORD_BYTES;

    typedef struct packed {
        ldr_state_e        st;
        logic [AW-1:0]     base;
        logic [CNT_W-1:0]  rem;
        logic              ld_valid;
        logic [AW-1:0]     ld_addr;
        logic [WORD_W-1:0] ld_count;
        logic              done;
    } ldr_t;

    ldr_t r_d, r_q;

    logic              g_clr, g_take, g_last;
    logic [1:0]        g_idx;
    logic [WORD_W-1:0] g_hi, g_lo;

    dcl_word_gather #(.WORD_W(WORD_W)) u_gather (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (g_clr),
        .take_i (g_take),
        .data_i (rd_data_i),
        .idx_o  (g_idx),
        .last_o (g_last),
        .hi_o   (g_hi),
        .lo_o   (g_lo)
    );

    always_comb begin
        r_d          = r_q;
        r_d.ld_valid = 1'b0;
        r_d.done     = 1'b0;
        g_clr        = 1'b0;
        g_take       = 1'b0;
        case (r_q.st)
            LDR_IDLE: begin
                if (start_i) begin
                    r_d.base = base_addr_i;
                    g_clr    = 1'b1;
                    if (blk_cnt_i != '0) begin
                        r_d.rem = blk_cnt_i - 1'b1;
                        r_d.st  = LDR_FETCH;
                    end else begin
                        r_d.rem = '0;
                        r_d.st  = LDR_RUN;
                    end
                end
            end
            LDR_FETCH: begin
                if (abort_i) begin
                    r_d.st = LDR_IDLE;
                    g_clr  = 1'b1;
                end else if (rd_valid_i) begin
                    g_take = 1'b1;
                    if (g_last) begin
                        r_d.ld_valid = 1'b1;
                        r_d.ld_addr  = {g_hi, g_lo};
                        r_d.ld_count = rd_data_i;
                        r_d.st       = LDR_RUN;
                    end
                end
            end
            LDR_RUN: begin
                if (abort_i) begin
                    r_d.st = LDR_IDLE;
                end else if (block_done_i) begin
                    if (r_q.rem != '0) begin
                        r_d.rem  = r_q.rem - 1'b1;
                        r_d.base = r_q.base + AW'(DESC_BYTES);
                        r_d.st   = LDR_FETCH;
                        g_clr    = 1'b1;
                    end else begin
                        r_d.done = 1'b1;
                        r_d.st   = LDR_IDLE;
                    end
                end
            end
            default: r_d.st = LDR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= LDR_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req_o     = (r_q.st == LDR_FETCH);
    assign rd_addr_o    = r_q.base + AW'(g_idx) * AW'(WORD_BYTES);
    assign ld_valid_o   = r_q.ld_valid;
    assign ld_addr_o    = r_q.ld_addr;
    assign ld_count_o   = r_q.ld_count;
    assign active_o     = (r_q.st != LDR_IDLE);
    assign chain_done_o = r_q.done;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_valid_i && !abort_i) |=> (rd_req_o && $stable(rd_addr_o)));  // R3

    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid_o |=> !ld_valid_o);  // R4

    AST_LOAD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid_o |-> (!rd_req_o && active_o));  // R4

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done_o |-> (!active_o && !rd_req_o));  // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done_o |=> !chain_done_o);  // R6

    AST_ABORT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && abort_i) |=> (!active_o && !ld_valid_o && !chain_done_o));  // R7

    AST_CONTINUE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !rd_req_o && block_done_i && !abort_i && !chain_done_o && $past(active_o))
            |=> (active_o || chain_done_o));  // R5

endmodule

// File: tb/tb_dma_chain_loader.sv
module tb_dma_chain_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_addr_i = '0;
    logic [15:0] blk_cnt_i = '0;
    logic        block_done_i = 1'b0;
    logic        abort_i = 1'b0;
    logic        rd_req_o;
    logic [31:0] rd_addr_o;
    logic        rd_valid_i = 1'b0;
    logic [15:0] rd_data_i = '0;
    logic        ld_valid_o;
    logic [31:0] ld_addr_o;
    logic [15:0] ld_count_o;
    logic        active_o;
    logic        chain_done_o;

    always #2.5 clk = ~clk;

    dma_chain_loader dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
        .blk_cnt_i(blk_cnt_i), .block_done_i(block_done_i), .abort_i(abort_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
        .rd_data_i(rd_data_i), .ld_valid_o(ld_valid_o), .ld_addr_o(ld_addr_o),
        .ld_count_o(ld_count_o), .active_o(active_o), .chain_done_o(chain_done_o)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] memw(input logic [31:0] a);
        return (a[15:0] ^ 16'hC3A5) + a[31:16] + 16'h0101;
    endfunction

    // behavioural reference: 0 idle, 1 fetching, 2 running
    int          m_mode = 0;
    int          m_words = 0;
    longint      m_ptr = 0;
    int          m_left = 0;
    logic [15:0] m_w [3];
    bit          m_ld = 0;
    longint      m_ld_addr = 0;
    int          m_ld_cnt = 0;
    bit          m_done = 0;
    int          n_loads = 0;
    int          n_dones = 0;
    int          n_reads = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_words = 0; m_ld = 0; m_done = 0;
        end else begin
            m_ld = 0; m_done = 0;
            if (m_mode == 0) begin
                if (start_i) begin
                    m_ptr = base_addr_i;
                    m_words = 0;
                    if (blk_cnt_i != 0) begin m_left = blk_cnt_i - 1; m_mode = 1; end
                    else begin m_left = 0; m_mode = 2; end
                end
            end else if (abort_i) begin
                m_mode = 0;
            end else if (m_mode == 1) begin
                if (rd_valid_i) begin
                    n_reads++;
                    m_w[m_words] = rd_data_i;
                    m_words++;
                    if (m_words == 3) begin
                        m_ld = 1;
                        m_ld_addr = {m_w[0], m_w[1]};
                        m_ld_cnt = m_w[2];
                        m_mode = 2;
                        m_words = 0;
                        n_loads++;
                    end
                end
            end else if (block_done_i) begin
                if (m_left > 0) begin
                    m_left--; m_ptr = (m_ptr + 6) & 64'hFFFF_FFFF; m_mode = 1; m_words = 0;
                end else begin
                    m_done = 1; m_mode = 0; n_dones++;
                end
            end
        end
    end

    // per-cycle comparison and memory responder
    int lat = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            check(active_o == (m_mode != 0), "R2", "active_o", active_o, m_mode != 0);
            check(rd_req_o == (m_mode == 1), "R3", "rd_req_o", rd_req_o, m_mode == 1);
            if (m_mode == 1)
                check(rd_addr_o == 32'(m_ptr + 2 * m_words), "R3", "rd_addr_o",
                      rd_addr_o, 32'(m_ptr + 2 * m_words));
            check(ld_valid_o == m_ld, "R4", "ld_valid_o", ld_valid_o, m_ld);
            if (m_ld) begin
                check(ld_addr_o == 32'(m_ld_addr), "R4", "ld_addr_o", ld_addr_o, m_ld_addr);
                check(ld_count_o == 16'(m_ld_cnt), "R4", "ld_count_o", ld_count_o, m_ld_cnt);
            end
            check(chain_done_o == m_done, "R6", "chain_done_o", chain_done_o, m_done);
        end
        if (rd_req_o) begin
            if (lat == 0) begin
                rd_valid_i <= 1'b1;
                rd_data_i  <= memw(rd_addr_o);
                lat = int'(rd_addr_o[3:1]) % 3;
            end else begin
                rd_valid_i <= 1'b0;
                lat--;
            end
        end else begin
            rd_valid_i <= 1'b0;
            lat = 0;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start(input logic [31:0] b, input logic [15:0] c);
        @(negedge clk); start_i <= 1'b1; base_addr_i <= b; blk_cnt_i <= c;
        @(negedge clk); start_i <= 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); block_done_i <= 1'b1;
        @(negedge clk); block_done_i <= 1'b0;
    endtask

    task automatic pulse_abort();
        @(negedge clk); abort_i <= 1'b1;
        @(negedge clk); abort_i <= 1'b0;
    endtask

    task automatic wait_run();
        int guard = 0;
        while (m_mode != 2 && guard < 100) begin @(negedge clk); guard++; end
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 20000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int l0, d0, r0;
        cyc(3);
        check(!active_o && !rd_req_o && !ld_valid_o && !chain_done_o, "R1", "reset outputs",
              {active_o, rd_req_o, ld_valid_o, chain_done_o}, 0);
        rst_n <= 1'b1;
        cyc(2);

        // three-block chain: R5 count of loads, R6 single completion
        l0 = n_loads; d0 = n_dones;
        pulse_start(32'h0001_0100, 16'd3);
        for (int b = 0; b < 3; b++) begin
            wait_run(); cyc(2);
            check(active_o && !chain_done_o, "R5", "active between blocks", active_o, 1);
            pulse_done();
        end
        cyc(2);
        check(n_loads - l0 == 3, "R5", "loads for count 3", n_loads - l0, 3);
        check(n_dones - d0 == 1, "R6", "dones for chain", n_dones - d0, 1);
        check(!active_o, "R6", "idle after chain", active_o, 0);

        // zero count: no reads, first block_done ends the chain (R2)
        r0 = n_reads; d0 = n_dones;
        pulse_start(32'h0000_2000, 16'd0);
        cyc(3);
        check(active_o && !rd_req_o, "R2", "zero count runs without reads", rd_req_o, 0);
        pulse_done();
        cyc(1);
        check(n_reads == r0, "R2", "no reads for zero count", n_reads - r0, 0);
        check(n_dones - d0 == 1, "R2", "zero count completion", n_dones - d0, 1);

        // abort after first word of a descriptor (R7)
        l0 = n_loads; d0 = n_dones;
        pulse_start(32'h00AB_0040, 16'd2);
        while (m_words < 1) @(negedge clk);
        abort_i <= 1'b1; @(negedge clk); abort_i <= 1'b0;
        cyc(4);
        check(!active_o && !rd_req_o, "R7", "idle after abort", active_o, 0);
        check(n_loads == l0 && n_dones == d0, "R7", "no load or done after abort",
              n_loads - l0 + n_dones - d0, 0);

        // abort during second descriptor, after two words
        pulse_start(32'h0000_0300, 16'd2);
        wait_run(); pulse_done();
        while (m_words < 2) @(negedge clk);
        pulse_abort();
        cyc(2);
        check(!active_o, "R7", "abort in second fetch", active_o, 0);

        // spurious start and block_done while fetching (R8)
        l0 = n_loads; d0 = n_dones;
        pulse_start(32'h0000_0500, 16'd2);
        @(negedge clk); start_i <= 1'b1; base_addr_i <= 32'h0000_7700; blk_cnt_i <= 16'd9;
        block_done_i <= 1'b1;
        @(negedge clk); start_i <= 1'b0; block_done_i <= 1'b0;
        wait_run(); cyc(1);
        check(ld_addr_o == {memw(32'h500), memw(32'h502)}, "R8", "spurious start ignored",
              ld_addr_o, {memw(32'h500), memw(32'h502)});
        pulse_done(); wait_run(); cyc(1);
        check(ld_count_o == memw(32'h50A), "R8", "second descriptor at +6",
              ld_count_o, memw(32'h50A));
        pulse_done(); cyc(2);
        check(n_loads - l0 == 2 && n_dones - d0 == 1, "R8", "loads and dones unchanged",
              n_loads - l0, 2);

        // single block, back-to-back restart
        pulse_start(32'hFFFF_FFF0, 16'd1);
        wait_run(); pulse_done();
        pulse_start(32'h0000_0010, 16'd1);
        wait_run(); cyc(1);
        check(ld_count_o == memw(32'h14), "R4", "count word at +4", ld_count_o, memw(32'h14));
        pulse_done(); cyc(3);
        check(!active_o, "R6", "final idle", active_o, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule